// File: doc/BRIEF.md
# Protected Page Memory Write Controller

This block holds a small page-organised memory of four pages of 32 bytes, stored in registers. Writes do not reach the pages directly. The host first opens an 8-byte staging buffer at a target address and streams bytes into it. It can then read the buffer back to verify the contents. Finally it issues a separate copy command, and the buffered bytes are committed to the page array at the end of a fixed programming interval.

Each page carries its own protection mode:

- **Open:** a commit replaces the stored bytes.
- **Clear-only:** a commit can only turn 1 bits into 0 bits.
- **Locked:** a commit leaves the page as it was.

Modes only ever become stricter.

During the programming interval the block reports busy and refuses every command. A copy whose address does not match the buffer's target row is refused and raises an error flag.

Top module: `pmw_ctrl`

## Requirements
- R1: After reset every memory byte reads 0xFF, every page mode reads 0 (open), and busy, copy_err, cmd_rej and rd_valid are low.
- R2: The command is held in cmd_op while cmd_valid is high. The codes are: 0 none, 1 open buffer, 2 buffer data, 3 read buffer, 4 copy, 5 read memory, 6 set mode, 7 read mode. The open command stores the target row (cmd_addr[6:3]) and sets the write offset to cmd_addr[2:0]. Each data command stores cmd_data at the offset and then advances the offset. A read-buffer command returns buffer byte cmd_addr[2:0] on rd_data, with rd_valid high in the following cycle.
- R3: Data bytes beyond buffer offset 7 are dropped, and the write offset never wraps. A copy changes only the bytes that were written since the last open command.
- R4: An accepted copy raises busy in the next cycle. Busy stays high for exactly PROG_CYCLES = (CLK_HZ/1e6)*PROG_US cycles. The page bytes take their new values in the cycle busy falls.
- R5: A copy is refused if its cmd_addr[6:3] differs from the stored row, or if no byte has been written since the last open. A refused copy does not raise busy, leaves memory unchanged, and sets copy_err in the next cycle. copy_err stays set until the next accepted open command.
- R6: While busy is high, every command is refused. A refused command pulses cmd_rej in the next cycle, gives no rd_valid, and changes no state.
- R7: Mode code 0 (open): a committed byte takes the buffer value.
- R8: Mode code 1 (clear-only): a committed byte becomes the old value AND the buffer value.
- R9: Mode code 2 (locked): a copy still runs its busy period, but the page bytes stay unchanged.
- R10: Set mode writes cmd_data[1:0] to page cmd_addr[6:5] only if the new code is greater than the current code and is at most 2. Code 3 and downgrades are ignored. Read mode returns the page's code in rd_data[1:0], with the other bits zero.
- R11: Read memory returns the byte at cmd_addr on rd_data, with rd_valid high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 7 | Byte address, buffer offset or page select |
| cmd_data | input | 8 | Data byte or mode code |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Programming interval in progress |
| copy_err | output | 1 | Last copy attempt refused |
| cmd_rej | output | 1 | Command refused because busy |

## Verification
The checker watches the programming interval on every cycle:

- Busy may rise only after a copy command.
- Busy must last exactly the programmed count.
- A command issued while busy must give a rejection and no read result.
- The error flag may rise only after a copy.
- No page mode may ever move back toward a weaker setting.

The data results need the bench's scenarios. These cover boundary truncation, writing only the touched bytes, the AND merge of clear-only pages, locked pages that keep their contents, and refused copies that leave memory untouched.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_OPEN    = 3'd1,
        OP_DATA    = 3'd2,
        OP_RBUF    = 3'd3,
        OP_COPY    = 3'd4,
        OP_RMEM    = 3'd5,
        OP_SETMODE = 3'd6,
        OP_RMODE   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        MODE_OPEN  = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_LOCK  = 2'd2
    } mode_e;

    // New stored value of one byte for a given page mode.
    function automatic logic [7:0] merge_byte(input logic [1:0] m,
                                              input logic [7:0] old_v,
                                              input logic [7:0] new_v);
        case (m)
            2'd0:    return new_v;
            2'd1:    return old_v & new_v;
            default: return old_v;
        endcase
    endfunction

endpackage

// File: rtl/pmw_stage_buf.sv
module pmw_stage_buf #(
    parameter int BUF_BYTES = 8,
    parameter int ROW_W     = 4,
    localparam int OFF_W    = $clog2(BUF_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       open_en,
    input  logic [ROW_W-1:0]           open_row,
    input  logic [OFF_W-1:0]           open_off,
    input  logic                       data_en,
    input  logic [7:0]                 data_in,
    output logic [BUF_BYTES-1:0][7:0]  buf_bytes,
    output logic [BUF_BYTES-1:0]       buf_mask,
    output logic [ROW_W-1:0]           buf_row
);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] bytes;
        logic [BUF_BYTES-1:0]      mask;
        logic [OFF_W:0]            ptr;
        logic [ROW_W-1:0]          row;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open_en) begin
            st_d.row  = open_row;
            st_d.ptr  = {1'b0, open_off};
            st_d.mask = '0;
        end else if (data_en && !st_q.ptr[OFF_W]) begin
            st_d.bytes[st_q.ptr[OFF_W-1:0]] = data_in;
            st_d.mask[st_q.ptr[OFF_W-1:0]]  = 1'b1;
            st_d.ptr                        = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_bytes = st_q.bytes;
    assign buf_mask  = st_q.mask;
    assign buf_row   = st_q.row;

endmodule

// File: rtl/pmw_mode_table.sv
module pmw_mode_table import pmw_pkg::*; #(
    parameter int PAGES   = 4,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [PAGE_W-1:0]      set_page,
    input  logic [1:0]             set_code,
    output logic [PAGES-1:0][1:0]  modes
);

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        logic [1:0] m_d, m_q;

        always_comb begin
            m_d = m_q;
            if (set_en && set_page == PAGE_W'(p) &&
                set_code > m_q && set_code <= MODE_LOCK)
                m_d = set_code;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) m_q <= MODE_OPEN;
            else        m_q <= m_d;
        end

        assign modes[p] = m_q;
    end

endmodule

// File: rtl/pmw_page_array.sv
module pmw_page_array import pmw_pkg::*; #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 32,
    parameter int BUF_BYTES  = 8,
    localparam int TOTAL     = PAGES * PAGE_BYTES,
    localparam int ADDR_W    = $clog2(TOTAL),
    localparam int OFF_W     = $clog2(BUF_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W,
    localparam int PAGE_W    = $clog2(PAGES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_en,
    input  logic [ROW_W-1:0]           commit_row,
    input  logic [BUF_BYTES-1:0][7:0]  buf_bytes,
    input  logic [BUF_BYTES-1:0]       buf_mask,
    input  logic [PAGES-1:0][1:0]      modes,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_byte
);

    logic [TOTAL-1:0][7:0] mem_d, mem_q;
    logic [PAGE_W-1:0]     page_sel;
    logic [1:0]            mode_sel;

    assign page_sel = commit_row[ROW_W-1 -: PAGE_W];
    assign mode_sel = modes[page_sel];

    always_comb begin
        mem_d = mem_q;
        if (commit_en) begin
            for (int b = 0; b < BUF_BYTES; b++) begin
                if (buf_mask[b])
                    mem_d[{commit_row, OFF_W'(b)}] =
                        merge_byte(mode_sel, mem_q[{commit_row, OFF_W'(b)}], buf_bytes[b]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= {TOTAL{8'hFF}};
        else        mem_q <= mem_d;
    end

    assign rd_byte = mem_q[rd_addr];

endmodule

// File: rtl/pmw_busy_timer.sv
module pmw_busy_timer #(
    parameter int CYCLES = 16,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.busy && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(CYCLES - 1);
        end else if (done) begin
            t_d.busy = 1'b0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

endmodule

// File: rtl/pmw_ctrl.sv
module pmw_ctrl import pmw_pkg::*; #(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 32,
    parameter int BUF_BYTES  = 8,
    parameter int CLK_HZ     = 50_000_000,
    parameter int PROG_US    = 10_000,
    localparam int ADDR_W    = $clog2(PAGES * PAGE_BYTES),
    localparam int OFF_W     = $clog2(BUF_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W,
    localparam int PAGE_W    = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              copy_err,
    output logic              cmd_rej
);

    localparam int CYC_RAW     = (CLK_HZ / 1_000_000) * PROG_US;
    localparam int PROG_CYCLES = (CYC_RAW < 1) ? 1 : CYC_RAW;

    typedef struct packed {
        logic       rd_valid;
        logic [7:0] rd_data;
        logic       err;
        logic       rej;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BUF_BYTES-1:0][7:0] buf_bytes;
    logic [BUF_BYTES-1:0]      buf_mask;
    logic [ROW_W-1:0]          buf_row;
    logic [PAGES-1:0][1:0]     modes;
    logic [7:0]                mem_rd;
    logic                      done;
    logic                      take, row_hit;
    logic                      open_en, data_en, copy_ok, mode_en;
    op_e                       op;

    always_comb begin
        op      = op_e'(cmd_op);
        take    = cmd_valid && !busy;
        row_hit = (cmd_addr[ADDR_W-1:OFF_W] == buf_row);
        open_en = take && (op == OP_OPEN);
        data_en = take && (op == OP_DATA);
        copy_ok = take && (op == OP_COPY) && row_hit && (|buf_mask);
        mode_en = take && (op == OP_SETMODE);
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.rej      = cmd_valid && busy;
        if (take) begin
            case (op)
                OP_OPEN: ctl_d.err = 1'b0;
                OP_COPY: if (!copy_ok) ctl_d.err = 1'b1;
                OP_RBUF: begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = buf_bytes[cmd_addr[OFF_W-1:0]];
                end
                OP_RMEM: begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = mem_rd;
                end
                OP_RMODE: begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_data  = {6'b0, modes[cmd_addr[ADDR_W-1 -: PAGE_W]]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pmw_stage_buf #(.BUF_BYTES(BUF_BYTES), .ROW_W(ROW_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (open_en),
        .open_row  (cmd_addr[ADDR_W-1:OFF_W]),
        .open_off  (cmd_addr[OFF_W-1:0]),
        .data_en   (data_en),
        .data_in   (cmd_data),
        .buf_bytes (buf_bytes),
        .buf_mask  (buf_mask),
        .buf_row   (buf_row)
    );

    pmw_mode_table #(.PAGES(PAGES)) u_modes (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (mode_en),
        .set_page (cmd_addr[ADDR_W-1 -: PAGE_W]),
        .set_code (cmd_data[1:0]),
        .modes    (modes)
    );

    pmw_page_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .BUF_BYTES(BUF_BYTES)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_en  (done),
        .commit_row (buf_row),
        .buf_bytes  (buf_bytes),
        .buf_mask   (buf_mask),
        .modes      (modes),
        .rd_addr    (cmd_addr),
        .rd_byte    (mem_rd)
    );

    pmw_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (copy_ok),
        .busy  (busy),
        .done  (done)
    );

    assign rd_valid = ctl_q.rd_valid;
    assign rd_data  = ctl_q.rd_data;
    assign copy_err = ctl_q.err;
    assign cmd_rej  = ctl_q.rej;

endmodule

// File: rtl/pmw_ctrl_chk.sv
module pmw_ctrl_chk #(
    parameter int PAGES       = 4,
    parameter int PROG_CYCLES = 1,
    localparam int RW         = $clog2(PROG_CYCLES + 2)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic                  busy,
    input logic                  rd_valid,
    input logic                  copy_err,
    input logic                  cmd_rej,
    input logic [PAGES-1:0][1:0] modes
);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_op) == 3'd4));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(PROG_CYCLES)));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != '0) |-> (run_q == RW'(PROG_CYCLES)));

    // R6
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (!rd_valid && cmd_rej));

    // R6
    rej_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rej |-> $past(busy));

    // R5
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_err) |-> ($past(cmd_valid) && $past(cmd_op) == 3'd4));

    for (genvar p = 0; p < PAGES; p++) begin : g_mode
        // R10
        mode_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (modes[p] >= $past(modes[p])) && (modes[p] != 2'd3));
    end

endmodule

bind pmw_ctrl pmw_ctrl_chk #(.PAGES(PAGES), .PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .copy_err  (copy_err),
    .cmd_rej   (cmd_rej),
    .modes     (modes)
);

// File: tb/sim_pmw_ctrl.sv
module sim_pmw_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PROG_US    = 40;
    localparam int PROG       = PROG_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [6:0] cmd_addr = 7'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       rd_valid, busy, copy_err, cmd_rej;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmw_ctrl #(.CLK_HZ(1_000_000), .PROG_US(PROG_US)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .copy_err(copy_err), .cmd_rej(cmd_rej)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [6:0] addr, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic rd_chk(input logic [2:0] op, input logic [6:0] addr,
                          input logic [7:0] exp, input string req);
        cmd(op, addr, 8'h00);
        chk(rd_valid, 1'b1, req);
        chk(rd_data, exp, req);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy, 0, "R1 busy");
        chk(copy_err, 0, "R1 copy_err");
        chk(cmd_rej, 0, "R1 cmd_rej");
        chk(rd_valid, 0, "R1 rd_valid");
        rd_chk(3'd5, 7'h05, 8'hFF, "R1 R11 erased byte");
        rd_chk(3'd7, 7'h60, 8'h00, "R1 mode open");
    endtask

    task automatic t_buffer();
        cmd(3'd1, 7'h08, 8'h00);
        for (int i = 0; i < 8; i++) cmd(3'd2, 7'h00, 8'hA0 + 8'(i));
        for (int i = 0; i < 8; i++) rd_chk(3'd3, 7'(i), 8'hA0 + 8'(i), "R2 buffer readback");
    endtask

    task automatic t_trunc();
        cmd(3'd1, 7'h16, 8'h00);
        cmd(3'd2, 7'h00, 8'h11);
        cmd(3'd2, 7'h00, 8'h22);
        cmd(3'd2, 7'h00, 8'h33);
        cmd(3'd2, 7'h00, 8'h44);
        rd_chk(3'd3, 7'd7, 8'h22, "R3 last slot");
        rd_chk(3'd3, 7'd0, 8'hA0, "R3 no wrap");
        cmd(3'd4, 7'h10, 8'h00);
        wait_idle();
        rd_chk(3'd5, 7'h15, 8'hFF, "R3 unwritten byte kept");
        rd_chk(3'd5, 7'h16, 8'h11, "R3 byte 6");
        rd_chk(3'd5, 7'h17, 8'h22, "R3 byte 7");
        rd_chk(3'd5, 7'h18, 8'hFF, "R3 next row untouched");
    endtask

    task automatic t_busy();
        int n;
        cmd(3'd1, 7'h00, 8'h00);
        cmd(3'd2, 7'h00, 8'h5A);
        cmd(3'd4, 7'h03, 8'h00);
        chk(busy, 1, "R4 busy after copy");
        n = 0;
        while (busy && n < 10 * PROG) begin
            n++;
            @(negedge clk);
        end
        chk(n, PROG, "R4 busy length");
        rd_chk(3'd5, 7'h00, 8'h5A, "R7 open page replace");
    endtask

    task automatic t_reject();
        cmd(3'd1, 7'h30, 8'h00);
        cmd(3'd2, 7'h00, 8'h77);
        cmd(3'd4, 7'h30, 8'h00);
        cmd(3'd5, 7'h30, 8'h00);
        chk(cmd_rej, 1, "R6 reject pulse");
        chk(rd_valid, 0, "R6 no read while busy");
        cmd(3'd2, 7'h00, 8'h00);
        wait_idle();
        rd_chk(3'd5, 7'h30, 8'h77, "R4 R6 commit intact");
        chk(cmd_rej, 0, "R6 no reject when idle");
    endtask

    task automatic t_mismatch();
        cmd(3'd1, 7'h38, 8'h00);
        cmd(3'd2, 7'h00, 8'h99);
        cmd(3'd4, 7'h40, 8'h00);
        chk(copy_err, 1, "R5 error on mismatch");
        chk(busy, 0, "R5 no busy on mismatch");
        rd_chk(3'd5, 7'h38, 8'hFF, "R5 memory unchanged");
        cmd(3'd1, 7'h38, 8'h00);
        chk(copy_err, 0, "R5 cleared by open");
        cmd(3'd4, 7'h38, 8'h00);
        chk(copy_err, 1, "R5 empty buffer refused");
        chk(busy, 0, "R5 empty no busy");
        cmd(3'd1, 7'h38, 8'h00);
    endtask

    task automatic t_clear_only();
        cmd(3'd1, 7'h20, 8'h00);
        cmd(3'd2, 7'h00, 8'h3C);
        cmd(3'd4, 7'h20, 8'h00);
        wait_idle();
        cmd(3'd6, 7'h20, 8'h01);
        rd_chk(3'd7, 7'h20, 8'h01, "R10 upgrade to clear-only");
        cmd(3'd1, 7'h20, 8'h00);
        cmd(3'd2, 7'h00, 8'h0F);
        cmd(3'd4, 7'h20, 8'h00);
        wait_idle();
        rd_chk(3'd5, 7'h20, 8'h0C, "R8 AND merge");
    endtask

    task automatic t_lock();
        cmd(3'd6, 7'h40, 8'h02);
        rd_chk(3'd7, 7'h40, 8'h02, "R10 lock set");
        cmd(3'd1, 7'h40, 8'h00);
        cmd(3'd2, 7'h00, 8'h12);
        cmd(3'd4, 7'h40, 8'h00);
        chk(busy, 1, "R9 locked copy still busy");
        wait_idle();
        rd_chk(3'd5, 7'h40, 8'hFF, "R9 locked page unchanged");
        cmd(3'd6, 7'h40, 8'h00);
        rd_chk(3'd7, 7'h40, 8'h02, "R10 lock is final");
        cmd(3'd6, 7'h20, 8'h00);
        rd_chk(3'd7, 7'h20, 8'h01, "R10 downgrade ignored");
        cmd(3'd6, 7'h60, 8'h03);
        rd_chk(3'd7, 7'h60, 8'h00, "R10 code 3 ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buffer();
        t_trunc();
        t_busy();
        t_reject();
        t_mismatch();
        t_clear_only();
        t_lock();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule